// File: doc/BRIEF.md
# Adaptive Dual Charge-Pump Phase/Frequency Detector

This block compares the output pulses of a synthesizer's reference divider and feedback divider. It produces digital pump-up and pump-down commands whose width is the phase error, counted in clock cycles. Because a pending command persists until the other divider fires, the detector also senses frequency error.

The commands feed two external charge pumps: a high-current pump and a low-current pump. Each pump has its own output-enable. A deasserted enable means the pump floats; it is never driven low. A 2-bit routing field picks which pumps are enabled. A force-float input overrides the routing and floats both pumps, so that modulation can be injected at the VCO.

An adapt timer supports fast acquisition. A divider-load strobe with a nonzero length starts the timer, and only the high-current pump is enabled while it runs. After the programmed number of reference pulses, the timer expires. Control then moves to the low-current pump, and a select output asks the dividers to use their alternate count values.

Top module: `adapt_pfd`

## Requirements
- R1: A rising edge of `ref_in`, with no feedback edge pending, sets `up` at that clock edge. `up` stays high until the clock edge that samples a rising edge of `fb_in`, so its width in cycles equals the edge separation.
- R2: Symmetrically, a rising edge of `fb_in` with no reference edge pending sets `dn` until the clock edge that samples a rising edge of `ref_in`.
- R3: `up` and `dn` are never high together. Rising edges of both inputs in the same cycle produce no pulse. An edge that arrives while the opposite command is pending clears both commands at that clock edge. A level held high counts only once.
- R4: With no adapt activity and `force_float` low, `pump_mode` sets the enables as follows. 00 floats both pumps. 01 enables the low-current pump only (`lo_oe`). 10 enables the high-current pump only (`hi_oe`). 11 enables both.
- R5: While `force_float` is high, `hi_oe` and `lo_oe` are both low, in every mode and in every adapt state.
- R6: A `load_strobe` with a nonzero `adapt_len` starts the adapt timer. From the next clock edge, `hi_oe`=1, `lo_oe`=0 and `alt_sel`=0, whatever `pump_mode` is.
- R7: The timer counts rising edges of `ref_in`. At the clock edge that samples edge number `adapt_len`, it expires: `hi_oe` falls, `lo_oe` rises and `alt_sel` rises. This state holds until the next `load_strobe`.
- R8: A `load_strobe` with `adapt_len` equal to 0 disables adapt. It clears `alt_sel`, and the enables follow `pump_mode`.
- R9: A `load_strobe` during a running timer restarts the count from zero. A strobe wins over a reference edge in the same cycle.
- R10: While `rst_n` is low, `up`, `dn` and `alt_sel` are 0, and the timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference-divider output |
| fb_in | input | 1 | Feedback-divider output |
| pump_mode | input | 2 | Pump routing: 00 none, 01 low, 10 high, 11 both |
| force_float | input | 1 | Floats both pumps |
| load_strobe | input | 1 | Divider load event; restarts the adapt timer |
| adapt_len | input | CW | Adapt length in reference edges, 0 = off |
| up | output | 1 | Pump-up command |
| dn | output | 1 | Pump-down command |
| hi_oe | output | 1 | High-current pump enable |
| lo_oe | output | 1 | Low-current pump enable |
| alt_sel | output | 1 | Alternate divider values select |

## Verification
The detector is swept with the reference leading and the feedback leading, at separations of 1 to 6 cycles. These runs show that pulse width tracks the edge separation and that polarity follows whichever input leads. Coincident edges confirm that no spurious pulse is produced. All mode and force-float combinations are swept, which separates the routing decode from the override. Adapt lengths of 1 to 5 are checked one edge at a time to locate the handoff on the exact edge. A restart in the middle of a count, and a zero length, show that the strobe resets the timer and that a zero length disables adapt.

// File: rtl/adapt_pfd.sv
module adapt_pfd #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_in,
  input  logic          fb_in,
  input  logic [1:0]    pump_mode,
  input  logic          force_float,
  input  logic          load_strobe,
  input  logic [CW-1:0] adapt_len,
  output logic          up,
  output logic          dn,
  output logic          hi_oe,
  output logic          lo_oe,
  output logic          alt_sel
);

  logic          ref_d, fb_d, up_q, dn_q, adapting;
  logic [CW-1:0] cnt, lim;

  wire ref_rise = ref_in & ~ref_d;
  wire fb_rise  = fb_in & ~fb_d;
  wire up_set   = up_q | ref_rise;
  wire dn_set   = dn_q | fb_rise;
  wire [CW-1:0] cnt_nxt = cnt + 1'b1;
  wire expire   = adapting & ref_rise & (cnt_nxt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d <= 1'b0;
      fb_d  <= 1'b0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      ref_d <= ref_in;
      fb_d  <= fb_in;
      up_q  <= up_set & ~dn_set;
      dn_q  <= dn_set & ~up_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adapting <= 1'b0;
      alt_sel  <= 1'b0;
      cnt      <= '0;
      lim      <= '0;
    end else if (load_strobe) begin
      adapting <= (adapt_len != '0);
      alt_sel  <= 1'b0;
      cnt      <= '0;
      lim      <= adapt_len;
    end else if (expire) begin
      adapting <= 1'b0;
      alt_sel  <= 1'b1;
    end else if (adapting && ref_rise) begin
      cnt <= cnt_nxt;
    end
  end

  assign up = up_q;
  assign dn = dn_q;
  assign hi_oe = ~force_float & (adapting | (~alt_sel & pump_mode[1]));
  assign lo_oe = ~force_float & ~adapting & (alt_sel | pump_mode[0]);

  a_r3_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && dn));
  a_r3_clear_on_meet: assert property (@(posedge clk) disable iff (!rst_n)
    (up && fb_rise) |=> (!up && !dn));
  a_r1_hold_up: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !fb_rise) |=> up);
  a_r7_expire_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alt_sel) |-> ($past(adapting) && $past(ref_rise)));
  a_r9_load_clears_alt: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |=> !alt_sel);
  a_r5_float: assert property (@(posedge clk) disable iff (!rst_n)
    force_float |-> (!hi_oe && !lo_oe));

endmodule

// File: tb/adapt_pfd_tb.sv
module adapt_pfd_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_in = 0, fb_in = 0, force_float = 0, load_strobe = 0;
  logic [1:0] pump_mode = 2'b00;
  logic [3:0] adapt_len = 4'd0;
  logic up, dn, hi_oe, lo_oe, alt_sel;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  adapt_pfd #(.CW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .pump_mode(pump_mode), .force_float(force_float),
    .load_strobe(load_strobe), .adapt_len(adapt_len),
    .up(up), .dn(dn), .hi_oe(hi_oe), .lo_oe(lo_oe), .alt_sel(alt_sel));

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got up,dn,hi,lo,alt=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] o();
    return {up, dn, hi_oe, lo_oe, alt_sel};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ref_in = 0; fb_in = 0; load_strobe = 0;
    force_float = 0; pump_mode = 2'b00;
    tick(); tick();
    @(negedge clk); rst_n = 1;
  endtask

  task automatic pair(bit ref_lead, int gap);
    @(negedge clk);
    if (ref_lead) ref_in = 1; else fb_in = 1;
    tick();
    chk(ref_lead ? "R1 lead" : "R2 lead", o(), {ref_lead, !ref_lead, 3'b000});
    for (int i = 1; i < gap; i++) begin
      @(negedge clk); ref_in = 0; fb_in = 0;
      tick();
      chk(ref_lead ? "R1 hold" : "R2 hold", o(), {ref_lead, !ref_lead, 3'b000});
    end
    @(negedge clk);
    if (ref_lead) begin ref_in = 0; fb_in = 1; end
    else begin fb_in = 0; ref_in = 1; end
    tick();
    chk("R3 meet clears", o(), 5'b00000);
    @(negedge clk); ref_in = 0; fb_in = 0;
    tick();
    chk("R3 idle after", o(), 5'b00000);
  endtask

  task automatic load(logic [3:0] len);
    @(negedge clk); load_strobe = 1; adapt_len = len;
    tick();
    @(negedge clk); load_strobe = 0;
  endtask

  task automatic ref_edge();
    @(negedge clk); ref_in = 1;
    tick();
  endtask

  task automatic ref_low();
    @(negedge clk); ref_in = 0; fb_in = 0;
    tick();
  endtask

  initial begin
    #(CLK_P * 20000);
    fails++; checks++;
    $display("FAIL watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1; tick();
    chk("R10 reset", o(), 5'b00000);
    do_reset();
    for (int g = 1; g <= 6; g++) begin
      pair(1'b1, g);
      pair(1'b0, g);
    end
    @(negedge clk); ref_in = 1; fb_in = 1;
    tick(); chk("R3 coincident", o(), 5'b00000);
    ref_low();
    ref_edge(); tick(); tick();
    chk("R3 level counts once", o(), 5'b10000);
    @(negedge clk); ref_in = 0; fb_in = 1; tick();
    chk("R3 long level cleared", o(), 5'b00000);
    ref_low();

    for (int m = 0; m < 4; m++) begin
      for (int f = 0; f < 2; f++) begin
        @(negedge clk); pump_mode = 2'(m); force_float = 1'(f);
        #1;
        chk(f ? "R5 force float" : "R4 mode decode", o(),
            {2'b00, m[1] & !f[0], m[0] & !f[0], 1'b0});
      end
    end
    @(negedge clk); force_float = 0; pump_mode = 2'b01;

    for (int len = 1; len <= 5; len++) begin
      do_reset();
      @(negedge clk); pump_mode = 2'b01;
      load(4'(len));
      chk("R6 adapt start", {hi_oe, lo_oe, alt_sel}, 5'b00100);
      for (int k = 1; k <= len; k++) begin
        ref_edge();
        if (k < len) chk("R6 still high", {hi_oe, lo_oe, alt_sel}, 5'b00100);
        else chk("R7 handoff", {hi_oe, lo_oe, alt_sel}, 5'b00011);
        ref_low();
      end
      ref_edge(); ref_low();
      chk("R7 holds", {hi_oe, lo_oe, alt_sel}, 5'b00011);
    end

    do_reset();
    @(negedge clk); pump_mode = 2'b00;
    load(4'd3);
    @(negedge clk); force_float = 1; #1;
    chk("R5 float during adapt", {hi_oe, lo_oe, alt_sel}, 5'b00000);
    @(negedge clk); force_float = 0;
    ref_edge(); ref_low(); ref_edge(); ref_low();
    load(4'd3);
    ref_edge(); ref_low(); ref_edge(); ref_low();
    chk("R9 restart", {hi_oe, lo_oe, alt_sel}, 5'b00100);
    ref_edge();
    chk("R9 expire after restart", {hi_oe, lo_oe, alt_sel}, 5'b00011);
    ref_low();

    @(negedge clk); load_strobe = 1; adapt_len = 4'd2; ref_in = 1;
    tick();
    @(negedge clk); load_strobe = 0; ref_in = 0;
    tick();
    ref_edge(); ref_low();
    chk("R9 strobe wins", {hi_oe, lo_oe, alt_sel}, 5'b00100);
    ref_edge(); ref_low();
    chk("R9 strobe wins expire", {hi_oe, lo_oe, alt_sel}, 5'b00011);

    @(negedge clk); pump_mode = 2'b10;
    load(4'd0);
    chk("R8 zero length", {hi_oe, lo_oe, alt_sel}, 5'b00100);
    ref_edge(); ref_low(); ref_edge(); ref_low();
    chk("R8 stays off", {hi_oe, lo_oe, alt_sel}, 5'b00100);
    @(negedge clk); pump_mode = 2'b01; #1;
    chk("R8 follows mode", {hi_oe, lo_oe, alt_sel}, 5'b00010);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule